// File: doc/BRIEF.md
# Delta-Modulation Sample Playback Channel

This block plays back a stream of one-bit delta codes read from memory and turns it into a seven-bit output level. Software programs four byte-wide control registers: a settings register, a direct level load, a start-address byte and a length byte. It then starts or stops playback through an enable write. While playback runs, a rate timer that advances on every other clock picks when the next code bit is applied. Each bit moves the level up or down by two, and the level holds at its limits instead of wrapping past them.

Sample bytes arrive over a read-request and read-response interface. A fetch is issued whenever the shifter has run out of bits and bytes remain. At the same moment a one-cycle stall pulse tells the processor that the memory cycle was taken; the processor holds for four cycles. The fetch address counts up, and past the top of the address space it returns to the middle of that space. When the last byte is fetched and looping is on, the address and length reload from the register values. A status output shows whether any bytes remain. The interrupt-enable setting is only stored and brought out.

Top module: `dpcm_channel`

## Requirements
- R1: After a synchronous reset the level is 0, no bytes remain (`active` = 0), no read is requested, the interrupt-enable output is 0, and the shifter's bit count is 8 with an all-zero shift byte.
- R2: A write to register 0 (`reg_sel` = 0) stores bit 7 as the interrupt enable shown on `irq_enable`, bit 6 as the loop enable, and bits 3:0 as a rate index. The index selects a timer period from {214,190,170,160,143,127,113,107,95,80,71,64,53,42,36,27}, with index 0 first. Bit shifts are then 2·(period+1) clocks apart.
- R3: A write to register 1 loads the level with bits 6:0 of the data. In a cycle where a shift would also change the level, the write wins.
- R4: A write to register 2 with byte d sets the start address to 0xC000 | (d << 6). A write to register 3 with byte d sets the length to (d << 4) | 1 bytes. Both take effect at the next restart.
- R5: The timer counts only on alternate clocks and only while enabled. On a counting clock, a timer at zero reloads the period and applies one shift. A timer that is not at zero decrements.
- R6: A shift takes bit 0 of the shift byte. A 1 adds 2 if the level is below 126. A 0 subtracts 2 if the level is above 1. The byte then shifts right and the bit count drops by one. When the bit count is 0, no shift takes place.
- R7: When enabled, with a bit count of 0, bytes remaining and no read outstanding, the block raises `rd_req` and `cpu_stall` for exactly one cycle, with the address on `rd_addr`. It makes no new request until `rd_valid` returns. The returned byte loads the shifter and sets the bit count to 8.
- R8: Each returned byte advances the address by one, and address 0xFFFF is followed by 0x8000. Each returned byte also lowers the bytes-remaining count by one.
- R9: If the returned byte takes the count from 1 to 0 while looping is on, the address and length reload from the register values, so `active` stays 1.
- R10: An enable write (`en_we`) with `en_val` = 0 disables the channel and clears bytes remaining. With `en_val` = 1 it enables the channel, and it restarts the address and length only when no bytes remain. `active` is 1 exactly while bytes remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 settings, 1 level, 2 start, 3 length) |
| reg_wdata | input | 8 | Register write data |
| en_we | input | 1 | Enable write strobe |
| en_val | input | 1 | Value written to the enable (1 start, 0 stop) |
| rd_req | output | 1 | One-cycle sample read request |
| rd_addr | output | 16 | Sample read address |
| rd_valid | input | 1 | Read response valid |
| rd_data | input | 8 | Read response byte |
| cpu_stall | output | 1 | One-cycle pulse per fetch to stall the processor |
| level_out | output | 7 | Current output level |
| active | output | 1 | Bytes remaining is nonzero |
| irq_enable | output | 1 | Stored interrupt-enable setting |

## Verification
A wrong bit count or shift byte first appears as a level step of the wrong sign, or of the wrong timing, at the next timer shot, at most one timer period later. The same fault also moves the next `rd_req` away from its 8-shift spacing. A wrong address or remaining count appears at the next fetch, either as a wrong `rd_addr` or as `active` dropping at the wrong byte. In loop mode it may never appear, unless the count reaches its end. A wrong timer phase or reload shows within two periods as shifted level edges and request spacing. That is why the request gap is measured against 2·8·(period+1) clocks.

// File: rtl/dpcm_pkg.sv
package dpcm_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 16;
    localparam int LEN_W  = 12;
    localparam int LVL_W  = 7;
    localparam int TMR_W  = 8;
    localparam int RATE_W = 4;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_LEVEL  = 2'd1,
        REG_START  = 2'd2,
        REG_LENGTH = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              irq_en;
        logic              loop_en;
        logic [RATE_W-1:0] rate;
    } ctrl_t;

    function automatic logic [TMR_W-1:0] rate_period(input logic [RATE_W-1:0] idx);
        logic [TMR_W-1:0] p;
        case (idx)
            4'd0:    p = 8'd214;
            4'd1:    p = 8'd190;
            4'd2:    p = 8'd170;
            4'd3:    p = 8'd160;
            4'd4:    p = 8'd143;
            4'd5:    p = 8'd127;
            4'd6:    p = 8'd113;
            4'd7:    p = 8'd107;
            4'd8:    p = 8'd95;
            4'd9:    p = 8'd80;
            4'd10:   p = 8'd71;
            4'd11:   p = 8'd64;
            4'd12:   p = 8'd53;
            4'd13:   p = 8'd42;
            4'd14:   p = 8'd36;
            default: p = 8'd27;
        endcase
        return p;
    endfunction

    function automatic logic [ADDR_W-1:0] start_of(input logic [BYTE_W-1:0] b);
        return {2'b11, b, 6'b000000};
    endfunction

    function automatic logic [LEN_W-1:0] length_of(input logic [BYTE_W-1:0] b);
        return {b, 4'b0001};
    endfunction

    function automatic logic [ADDR_W-1:0] advance(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] n;
        if (a == {ADDR_W{1'b1}})
            n = {1'b1, {(ADDR_W-1){1'b0}}};
        else
            n = a + 1'b1;
        return n;
    endfunction
endpackage

// File: rtl/dpcm_timer.sv
module dpcm_timer #(
    parameter int TW = dpcm_pkg::TMR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [TW-1:0] period,
    output logic          fire
);
    logic          phase_q;
    logic [TW-1:0] cnt_q;
    logic          step;

    assign step = phase_q & run;
    assign fire = step && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            phase_q <= ~phase_q;
            if (step) begin
                if (cnt_q == '0)
                    cnt_q <= period;
                else
                    cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R5
    alt_clock_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire);

    // R5
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> (cnt_q == $past(period)));
endmodule

// File: rtl/dpcm_shifter.sv
module dpcm_shifter #(
    parameter int BW = dpcm_pkg::BYTE_W,
    parameter int LW = dpcm_pkg::LVL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fire,
    input  logic          load_byte,
    input  logic [BW-1:0] byte_in,
    input  logic          lvl_load,
    input  logic [LW-1:0] lvl_val,
    output logic          bits_empty,
    output logic [LW-1:0] level
);
    localparam int CW = $clog2(BW + 1);
    localparam logic [LW-1:0] LVL_HI = LW'((1 << LW) - 2);
    localparam logic [LW-1:0] LVL_LO = LW'(1);
    localparam logic [LW-1:0] STEP   = LW'(2);

    logic [BW-1:0] sr_q;
    logic [CW-1:0] bits_q;
    logic          do_shift;

    assign bits_empty = (bits_q == '0);
    assign do_shift   = fire && !bits_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q   <= '0;
            bits_q <= CW'(BW);
            level  <= '0;
        end else begin
            if (load_byte) begin
                sr_q   <= byte_in;
                bits_q <= CW'(BW);
            end else if (do_shift) begin
                sr_q   <= sr_q >> 1;
                bits_q <= bits_q - 1'b1;
            end
            if (lvl_load) begin
                level <= lvl_val;
            end else if (do_shift) begin
                if (sr_q[0]) begin
                    if (level < LVL_HI) level <= level + STEP;
                end else begin
                    if (level > LVL_LO) level <= level - STEP;
                end
            end
        end
    end

    // R6
    level_step_chk: assert property (@(posedge clk) disable iff (rst)
        !lvl_load |=> ((int'(level) - int'($past(level))) inside {-2, 0, 2}));

    // R6
    bit_count_chk: assert property (@(posedge clk) disable iff (rst)
        int'(bits_q) <= BW);

    // R7
    load_when_empty_chk: assert property (@(posedge clk) disable iff (rst)
        load_byte |-> bits_empty);
endmodule

// File: rtl/dpcm_fetcher.sv
module dpcm_fetcher #(
    parameter int AW = dpcm_pkg::ADDR_W,
    parameter int NW = dpcm_pkg::LEN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_we,
    input  logic          en_val,
    input  logic [AW-1:0] start_addr,
    input  logic [NW-1:0] start_len,
    input  logic          loop_en,
    input  logic          bits_empty,
    input  logic          rd_valid,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    output logic          active,
    output logic          enabled
);
    logic [AW-1:0] addr_q;
    logic [NW-1:0] remain_q;
    logic          pending_q;
    logic          req_q;
    logic          can_fetch;

    assign active    = (remain_q != '0);
    assign can_fetch = enabled && bits_empty && active && !pending_q;
    assign rd_req    = req_q;
    assign rd_addr   = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            enabled   <= 1'b0;
            addr_q    <= '0;
            remain_q  <= '0;
            pending_q <= 1'b0;
            req_q     <= 1'b0;
        end else begin
            req_q <= can_fetch;
            if (can_fetch)
                pending_q <= 1'b1;
            else if (rd_valid)
                pending_q <= 1'b0;

            if (en_we && !en_val) begin
                enabled  <= 1'b0;
                remain_q <= '0;
            end else if (en_we && !active) begin
                enabled  <= 1'b1;
                addr_q   <= start_addr;
                remain_q <= start_len;
            end else begin
                if (en_we)
                    enabled <= 1'b1;
                if (rd_valid) begin
                    if (remain_q == NW'(1) && loop_en) begin
                        addr_q   <= start_addr;
                        remain_q <= start_len;
                    end else begin
                        addr_q <= dpcm_pkg::advance(addr_q);
                        if (active)
                            remain_q <= remain_q - 1'b1;
                    end
                end
            end
        end
    end

    // R7
    req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req);

    // R8
    upper_half_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> rd_addr[AW-1]);

    // R10
    stop_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (en_we && !en_val) |=> !active);

    // R10
    start_loads_chk: assert property (@(posedge clk) disable iff (rst)
        (en_we && en_val && !active) |=> (active && enabled));
endmodule

// File: rtl/dpcm_channel.sv
module dpcm_channel (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          reg_we,
    input  logic [1:0]                    reg_sel,
    input  logic [dpcm_pkg::BYTE_W-1:0]   reg_wdata,
    input  logic                          en_we,
    input  logic                          en_val,
    output logic                          rd_req,
    output logic [dpcm_pkg::ADDR_W-1:0]   rd_addr,
    input  logic                          rd_valid,
    input  logic [dpcm_pkg::BYTE_W-1:0]   rd_data,
    output logic                          cpu_stall,
    output logic [dpcm_pkg::LVL_W-1:0]    level_out,
    output logic                          active,
    output logic                          irq_enable
);
    import dpcm_pkg::*;

    ctrl_t             ctrl_q;
    logic [BYTE_W-1:0] start_byte_q;
    logic [BYTE_W-1:0] len_byte_q;
    reg_sel_e          sel;
    logic              lvl_load;
    logic              fire;
    logic              bits_empty;
    logic              enabled;

    assign sel      = reg_sel_e'(reg_sel);
    assign lvl_load = reg_we && (sel == REG_LEVEL);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q       <= '0;
            start_byte_q <= '0;
            len_byte_q   <= '0;
        end else if (reg_we) begin
            case (sel)
                REG_CTRL: begin
                    ctrl_q.irq_en  <= reg_wdata[7];
                    ctrl_q.loop_en <= reg_wdata[6];
                    ctrl_q.rate    <= reg_wdata[RATE_W-1:0];
                end
                REG_START:  start_byte_q <= reg_wdata;
                REG_LENGTH: len_byte_q   <= reg_wdata;
                default: ;
            endcase
        end
    end

    assign irq_enable = ctrl_q.irq_en;
    assign cpu_stall  = rd_req;

    dpcm_timer #(.TW(TMR_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (enabled),
        .period (rate_period(ctrl_q.rate)),
        .fire   (fire)
    );

    dpcm_shifter #(.BW(BYTE_W), .LW(LVL_W)) u_shifter (
        .clk        (clk),
        .rst        (rst),
        .fire       (fire),
        .load_byte  (rd_valid),
        .byte_in    (rd_data),
        .lvl_load   (lvl_load),
        .lvl_val    (reg_wdata[LVL_W-1:0]),
        .bits_empty (bits_empty),
        .level      (level_out)
    );

    dpcm_fetcher #(.AW(ADDR_W), .NW(LEN_W)) u_fetcher (
        .clk        (clk),
        .rst        (rst),
        .en_we      (en_we),
        .en_val     (en_val),
        .start_addr (start_of(start_byte_q)),
        .start_len  (length_of(len_byte_q)),
        .loop_en    (ctrl_q.loop_en),
        .bits_empty (bits_empty),
        .rd_valid   (rd_valid),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .active     (active),
        .enabled    (enabled)
    );

    // R2
    irq_store_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && sel == REG_CTRL) |=> (irq_enable == $past(reg_wdata[7])));

    // R3
    level_load_chk: assert property (@(posedge clk) disable iff (rst)
        lvl_load |=> (level_out == $past(reg_wdata[LVL_W-1:0])));
endmodule

// File: tb/dpcm_channel_test.sv
module dpcm_channel_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic        en_we = 1'b0;
    logic        en_val = 1'b0;
    logic        rd_req;
    logic [15:0] rd_addr;
    logic        rd_valid = 1'b0;
    logic [7:0]  rd_data = 8'd0;
    logic        cpu_stall;
    logic [6:0]  level_out;
    logic        active;
    logic        irq_enable;

    dpcm_channel uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .en_we(en_we), .en_val(en_val),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
        .rd_data(rd_data), .cpu_stall(cpu_stall), .level_out(level_out),
        .active(active), .irq_enable(irq_enable)
    );

    always #5 clk = ~clk;

    int errors = 0;
    int checks = 0;
    int cycle  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int m_phase, m_en, m_tcnt, m_sr, m_bits, m_lvl, m_addr, m_rem, m_pend, m_req;
    int m_irq, m_loop, m_rate, m_startb, m_lenb;
    int t_step, t_fire, t_shift, t_can, t_lvl;
    int periods[16] = '{214,190,170,160,143,127,113,107,95,80,71,64,53,42,36,27};

    always @(posedge clk) begin
        cycle++;
        if (rst) begin
            m_phase = 0; m_en = 0; m_tcnt = 0; m_sr = 0; m_bits = 8; m_lvl = 0;
            m_addr = 0; m_rem = 0; m_pend = 0; m_req = 0;
            m_irq = 0; m_loop = 0; m_rate = 0; m_startb = 0; m_lenb = 0;
        end else begin
            t_step  = (m_phase != 0 && m_en != 0) ? 1 : 0;
            t_fire  = (t_step != 0 && m_tcnt == 0) ? 1 : 0;
            t_shift = (t_fire != 0 && m_bits != 0) ? 1 : 0;
            t_can   = (m_en != 0 && m_bits == 0 && m_rem != 0 && m_pend == 0) ? 1 : 0;
            t_lvl = m_lvl;
            if (reg_we && reg_sel == 2'd1) t_lvl = reg_wdata % 128;
            else if (t_shift != 0) begin
                if (m_sr % 2 == 1) begin if (m_lvl < 126) t_lvl = m_lvl + 2; end
                else if (m_lvl > 1) t_lvl = m_lvl - 2;
            end
            if (t_step != 0) m_tcnt = (m_tcnt == 0) ? periods[m_rate] : m_tcnt - 1;
            if (rd_valid) begin m_sr = rd_data; m_bits = 8; end
            else if (t_shift != 0) begin m_sr = m_sr / 2; m_bits = m_bits - 1; end
            if (en_we && !en_val) begin m_en = 0; m_rem = 0; end
            else if (en_we && m_rem == 0) begin
                m_en = 1; m_addr = 49152 + m_startb * 64; m_rem = m_lenb * 16 + 1;
            end else begin
                if (en_we) m_en = 1;
                if (rd_valid) begin
                    if (m_rem == 1 && m_loop != 0) begin
                        m_addr = 49152 + m_startb * 64; m_rem = m_lenb * 16 + 1;
                    end else begin
                        m_addr = (m_addr == 65535) ? 32768 : m_addr + 1;
                        if (m_rem != 0) m_rem = m_rem - 1;
                    end
                end
            end
            if (t_can != 0) m_pend = 1; else if (rd_valid) m_pend = 0;
            m_req = t_can;
            m_lvl = t_lvl;
            m_phase = 1 - m_phase;
            if (reg_we) begin
                case (reg_sel)
                    2'd0: begin m_irq = reg_wdata[7]; m_loop = reg_wdata[6]; m_rate = reg_wdata[3:0]; end
                    2'd2: m_startb = reg_wdata;
                    2'd3: m_lenb = reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            chk(int'(level_out) == m_lvl, "R6", "level vs model", level_out, m_lvl);
            chk(int'(active) == (m_rem != 0 ? 1 : 0), "R10", "active vs model", active, m_rem != 0);
            chk(int'(rd_req) == m_req, "R7", "rd_req vs model", rd_req, m_req);
            chk(int'(cpu_stall) == m_req, "R7", "cpu_stall vs model", cpu_stall, m_req);
            chk(int'(rd_addr) == m_addr, "R8", "rd_addr vs model", rd_addr, m_addr);
            chk(int'(irq_enable) == m_irq, "R2", "irq_enable vs model", irq_enable, m_irq);
        end
    end

    // ---------------- memory responder ----------------
    int mem_mode = 0;
    int lat_cnt = 0;
    int lat_sel = 1;
    logic [15:0] hold_addr = 16'd0;
    logic [15:0] fq[$];
    int last_req_cyc = 0;
    int req_gap = 0;

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        if (mem_mode == 1) return 8'hFF;
        if (mem_mode == 2) return 8'h00;
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    always @(negedge clk) begin
        rd_valid = 1'b0;
        if (lat_cnt > 0) begin
            lat_cnt--;
            if (lat_cnt == 0) begin
                rd_valid = 1'b1;
                rd_data  = mem_byte(hold_addr);
            end
        end
        if (rd_req) begin
            hold_addr = rd_addr;
            fq.push_back(rd_addr);
            lat_cnt = lat_sel;
            lat_sel = (lat_sel % 3) + 1;
            req_gap = cycle - last_req_cyc;
            last_req_cyc = cycle;
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic set_en(input logic v);
        @(negedge clk);
        en_we = 1'b1; en_val = v;
        @(negedge clk);
        en_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_fetches(input int n);
        int target;
        target = fq.size() + n;
        while (fq.size() < target) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        while (cycle < 180000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cycle, 0);
        finish_run();
    end

    initial begin
        idle(3);
        // R1 reset state
        chk(level_out == 7'd0, "R1", "reset level", level_out, 0);
        chk(active == 1'b0, "R1", "reset active", active, 0);
        chk(rd_req == 1'b0, "R1", "reset rd_req", rd_req, 0);
        chk(irq_enable == 1'b0, "R1", "reset irq_enable", irq_enable, 0);
        rst = 1'b0;
        idle(4);
        chk(level_out == 7'd0 && !active && !rd_req, "R1", "idle after reset", level_out, 0);

        // R2 settings: irq on, rate 15
        wr(2'd0, 8'h8F);
        chk(irq_enable == 1'b1, "R2", "irq_enable set", irq_enable, 1);
        // R3 direct level load
        wr(2'd1, 8'd64);
        chk(level_out == 7'd64, "R3", "level load", level_out, 64);
        // R4 start 0xFFC0, length 65 bytes
        wr(2'd2, 8'hFF);
        wr(2'd3, 8'h04);
        fq.delete();
        set_en(1'b1);
        chk(active == 1'b1, "R10", "enable restarts", active, 1);
        wait_fetches(4);
        // R5 request spacing = 8 shifts * 2 * (27+1)
        chk(req_gap == 448, "R5", "fetch gap rate 15", req_gap, 448);
        wr(2'd1, 8'h85);
        // R3 bits 6:0 only
        chk(level_out == 7'd5, "R3", "level load masks bit 7", level_out, 5);
        while (active) @(negedge clk);
        chk(fq.size() == 65, "R4", "fetch count for length byte 4", fq.size(), 65);
        chk(fq[0] == 16'hFFC0, "R4", "first fetch address", fq[0], 16'hFFC0);
        chk(fq[63] == 16'hFFFF && fq[64] == 16'h8000, "R8", "wrap to 0x8000", fq[64], 16'h8000);
        idle(600);

        // R6 upper clamp with ones, R9 looping of a one-byte sample
        mem_mode = 1;
        wr(2'd0, 8'h4F);
        chk(irq_enable == 1'b0, "R2", "irq_enable cleared", irq_enable, 0);
        wr(2'd2, 8'h00);
        wr(2'd3, 8'h00);
        wr(2'd1, 8'd125);
        fq.delete();
        set_en(1'b1);
        wait_fetches(3);
        idle(100);
        chk(level_out == 7'd127, "R6", "clamp from 125", level_out, 127);
        chk(active == 1'b1, "R9", "looping keeps active", active, 1);
        chk(fq[1] == 16'hC000 && fq[2] == 16'hC000, "R9", "loop restart address", fq[2], 16'hC000);
        wr(2'd1, 8'd126);
        idle(200);
        chk(level_out == 7'd126, "R6", "126 holds on ones", level_out, 126);

        // R6 lower clamp with zeros
        mem_mode = 2;
        wait_fetches(2);
        wr(2'd1, 8'd3);
        idle(300);
        chk(level_out == 7'd1, "R6", "clamp from 3", level_out, 1);
        wr(2'd1, 8'd2);
        idle(300);
        chk(level_out == 7'd0, "R6", "2 falls to 0", level_out, 0);

        // R10 disable clears remaining
        mem_mode = 0;
        set_en(1'b0);
        chk(active == 1'b0, "R10", "disable clears", active, 0);
        idle(20);
        wr(2'd0, 8'h0F);
        wr(2'd2, 8'h10);
        wr(2'd3, 8'h01);
        fq.delete();
        set_en(1'b1);
        wait_fetches(3);
        set_en(1'b1);
        chk(active == 1'b1, "R10", "re-enable keeps active", active, 1);
        wait_fetches(1);
        chk(fq[0] == 16'hC400, "R4", "start byte 0x10", fq[0], 16'hC400);
        chk(fq[3] == 16'hC403, "R10", "no restart while bytes remain", fq[3], 16'hC403);

        // R2 slowest rate with looping
        set_en(1'b0);
        wr(2'd0, 8'h40);
        wr(2'd3, 8'h00);
        set_en(1'b1);
        wait_fetches(4);
        chk(req_gap == 3440, "R2", "fetch gap rate 0", req_gap, 3440);
        idle(50);
        finish_run();
    end
endmodule